// File: doc/BRIEF.md
# Bit-Plane Search Array

This block is a search memory whose records are kept sideways. Each stored record occupies one column, and each row of the store holds a single bit significance across all records. Reading one row therefore returns the same bit of every record at once. A host loads records through a plain write port. It then starts a search with a key and a care mask. The array steps through the bit rows in order, one per cycle. Next to every column sits a one-bit operator that drops the column's match flag as soon as a cared-for bit disagrees with the key.

Search time depends only on the record width and never on the number of records. No index or preprocessing is needed: to change the data, the host rewrites the record. After the scan, a two-cycle result stage publishes three results. These are the full match vector, the lowest matching record number with a valid bit, and the number of matching records. Several arrays placed side by side each evaluate their own records in the same time. Constant patterns, such as an all-zero record, are found by searching with that constant as the key and a full mask.

Top module: `bitplane_search`

## Requirements
- R1: After reset, busy, done, hit_valid, match_vec, hit_index and match_count are all zero.
- R2: After a search, match_vec bit c is 1 exactly when, for every bit k with mask bit k equal to 1, bit k of stored record c equals key bit k.
- R3: A mask of all zeros makes every record match, so match_count equals NREC and hit_index is 0.
- R4: A start accepted while idle raises busy for exactly WIDTH+2 cycles. done is high for one cycle, in the first cycle in which busy is low again.
- R5: hit_index is the lowest record number whose match bit is 1, and hit_valid is 1. When no record matches, hit_valid is 0 and hit_index is 0.
- R6: match_count equals the number of 1 bits in match_vec.
- R7: While busy is high, wr_en and start are ignored. No stored record changes, and the running search neither restarts nor lengthens.
- R8: A write while idle stores bit k of wr_data as bit k of record wr_addr and replaces that record's previous contents. The next search sees the new value.
- R9: Searching with key 0 and an all-ones mask reports exactly the records whose stored value is all zeros.
- R10: match_vec, hit_index, hit_valid and match_count keep their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Record write request, honoured only while idle |
| wr_addr | input | $clog2(NREC) | Record (column) number to write |
| wr_data | input | WIDTH | Record value; bit k goes to row k |
| start | input | 1 | Search request, honoured only while idle |
| key | input | WIDTH | Search key, captured with start |
| mask | input | WIDTH | Care mask; a 1 bit means the bit is compared |
| busy | output | 1 | High from the cycle after start until the results are out |
| done | output | 1 | One-cycle pulse when new results are published |
| match_vec | output | NREC | Per-record match flags |
| hit_index | output | $clog2(NREC) | Lowest matching record number |
| hit_valid | output | 1 | At least one record matched |
| match_count | output | $clog2(NREC+1) | Number of matching records |

## Verification
The hardest cases to reach from the ports are requests that arrive in the middle of a scan: a write or a second start issued while the array is partway through its bit rows. The bench injects a write to a record that the running key targets, and a start carrying a different key, several cycles into a search. It then checks three things: that the reported result belongs to the original key and the original data, that busy lasted exactly WIDTH+2 cycles, and that a later search still sees the unmodified record. A no-match search, an all-zeros mask, the all-zero pattern and a match found only in the top record cover the two ends of the encoder.

// File: rtl/bps_pkg.sv
// Shared types for the bit-plane search array.
// Assumes nothing beyond a single clock domain.
package bps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_ENC  = 2'd2,
        ST_OUT  = 2'd3
    } bps_state_t;
endpackage

// File: rtl/bps_plane_store.sv
// Transposed record storage: row k holds bit k of every record.
// A write places bit k of the word into row k of one column. The read
// side returns one whole row, selected by the scan counter.
// Assumes the caller already gates writes to idle periods.
module bps_plane_store #(
    parameter int NREC  = 64,
    parameter int WIDTH = 16,
    localparam int IDXW = (NREC > 1) ? $clog2(NREC) : 1,
    localparam int ROWW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic [IDXW-1:0]  wr_col,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [ROWW-1:0]  rd_row,
    input  logic             busy,
    output logic [NREC-1:0]  row_bits
);
    logic [WIDTH-1:0][NREC-1:0] planes;

    // Store each bit of the incoming word into its own row of the column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            planes <= '0;
        end else if (wr_go) begin
            for (int k = 0; k < WIDTH; k++) begin
                planes[k][wr_col] <= wr_word[k];
            end
        end
    end

    // Present the selected bit row to all column operators
    always_comb begin
        row_bits = planes[rd_row];
    end

    // R7: no record bit may change while a search is running
    a_r7_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(planes));
endmodule

// File: rtl/bps_match_cols.sv
// One match flag per record column. Every flag is set on search start.
// In each scan cycle the flag is cleared when the row is cared for and the
// column's bit differs from the key bit. All columns act in the same cycle.
// Assumes init and scan are never high together.
module bps_match_cols #(
    parameter int NREC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            scan,
    input  logic [NREC-1:0] row_bits,
    input  logic            key_bit,
    input  logic            care_bit,
    output logic [NREC-1:0] flags
);
    for (genvar c = 0; c < NREC; c++) begin : g_col
        logic f;

        // Per-column operator: arm on start, drop on a cared mismatch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f <= 1'b0;
            end else if (init) begin
                f <= 1'b1;
            end else if (scan && care_bit && (row_bits[c] != key_bit)) begin
                f <= 1'b0;
            end
        end

        assign flags[c] = f;
    end

    // R2: during a scan, flags can only be cleared, never set
    a_r2_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && $past(scan)) |-> ((flags & ~$past(flags)) == '0));
endmodule

// File: rtl/bps_result_enc.sv
// Two-stage result encoder. Stage one captures the finished flags and
// computes the lowest set index and the population count. Stage two
// publishes them at the block outputs, where they hold until the next publish.
// Assumes flags are stable in the capture cycle.
module bps_result_enc #(
    parameter int NREC = 64,
    localparam int IDXW = (NREC > 1) ? $clog2(NREC) : 1,
    localparam int CNTW = $clog2(NREC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            publish,
    input  logic [NREC-1:0] flags,
    output logic [NREC-1:0] match_vec,
    output logic [IDXW-1:0] hit_index,
    output logic            hit_valid,
    output logic [CNTW-1:0] match_count
);
    logic [IDXW-1:0] first_c;
    logic            found_c;
    logic [CNTW-1:0] cnt_c;
    logic [NREC-1:0] s_vec;
    logic [IDXW-1:0] s_first;
    logic            s_found;
    logic [CNTW-1:0] s_cnt;

    // Priority search for the lowest set flag
    always_comb begin
        first_c = '0;
        found_c = 1'b0;
        for (int i = NREC - 1; i >= 0; i--) begin
            if (flags[i]) begin
                first_c = IDXW'(i);
                found_c = 1'b1;
            end
        end
    end

    // Population count of the flags
    always_comb begin
        cnt_c = '0;
        for (int i = 0; i < NREC; i++) begin
            cnt_c = cnt_c + CNTW'(flags[i]);
        end
    end

    // Stage one: capture encoded results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vec   <= '0;
            s_first <= '0;
            s_found <= 1'b0;
            s_cnt   <= '0;
        end else if (capture) begin
            s_vec   <= flags;
            s_first <= first_c;
            s_found <= found_c;
            s_cnt   <= cnt_c;
        end
    end

    // Stage two: publish to the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec   <= '0;
            hit_index   <= '0;
            hit_valid   <= 1'b0;
            match_count <= '0;
        end else if (publish) begin
            match_vec   <= s_vec;
            hit_index   <= s_first;
            hit_valid   <= s_found;
            match_count <= s_cnt;
        end
    end

    // R5: a valid hit index points at a set match bit
    a_r5_first_is_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> match_vec[hit_index]);
    // R5/R6: valid agrees with a non-zero count
    a_r6_valid_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid == (match_count != '0));
    // R6: count agrees with the published vector
    a_r6_count_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
        match_count == CNTW'($countones(match_vec)));
    // R10: outputs only move on a publish
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(publish) |-> ($stable(match_vec) && $stable(hit_index)
                             && $stable(match_count)));
endmodule

// File: rtl/bitplane_search.sv
// Top of the bit-plane search array. It sequences idle, one scan cycle per
// bit row, then capture and publish. It gates writes and starts to the idle
// state and produces busy and the done pulse.
// Assumes key and mask are valid in the cycle start is high.
module bitplane_search
    import bps_pkg::*;
#(
    parameter int NREC  = 64,
    parameter int WIDTH = 16,
    localparam int IDXW = (NREC > 1) ? $clog2(NREC) : 1,
    localparam int ROWW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int CNTW = $clog2(NREC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             start,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] mask,
    output logic             busy,
    output logic             done,
    output logic [NREC-1:0]  match_vec,
    output logic [IDXW-1:0]  hit_index,
    output logic             hit_valid,
    output logic [CNTW-1:0]  match_count
);
    bps_state_t      state;
    logic [ROWW-1:0] row;
    logic [WIDTH-1:0] key_q;
    logic [WIDTH-1:0] mask_q;
    logic [NREC-1:0] row_bits;
    logic [NREC-1:0] flags;
    logic            idle;
    logic            accept;
    logic            wr_go;
    logic            scan;

    assign idle   = (state == ST_IDLE);
    assign accept = idle && start;
    assign wr_go  = idle && wr_en;
    assign scan   = (state == ST_SCAN);
    assign busy   = !idle;

    // Sequencer: row walk, then encode and publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            row    <= '0;
            key_q  <= '0;
            mask_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        key_q  <= key;
                        mask_q <= mask;
                        row    <= '0;
                        state  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (row == ROWW'(WIDTH - 1)) begin
                        state <= ST_ENC;
                    end else begin
                        row <= row + 1'b1;
                    end
                end
                ST_ENC: begin
                    state <= ST_OUT;
                end
                default: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            endcase
        end
    end

    bps_plane_store #(.NREC(NREC), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .wr_col   (wr_addr),
        .wr_word  (wr_data),
        .rd_row   (row),
        .busy     (busy),
        .row_bits (row_bits)
    );

    bps_match_cols #(.NREC(NREC)) u_cols (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (accept),
        .scan     (scan),
        .row_bits (row_bits),
        .key_bit  (key_q[row]),
        .care_bit (mask_q[row]),
        .flags    (flags)
    );

    bps_result_enc #(.NREC(NREC)) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (state == ST_ENC),
        .publish     (state == ST_OUT),
        .flags       (flags),
        .match_vec   (match_vec),
        .hit_index   (hit_index),
        .hit_valid   (hit_valid),
        .match_count (match_count)
    );

    // R4: done lasts exactly one cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: done appears only as busy falls
    a_r4_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R7: a start while busy does not rewind the row walk
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && $past(scan)) |-> (row == $past(row) + 1'b1));
endmodule

// File: tb/bitplane_search_test.sv
module bitplane_search_test;
    localparam int NREC  = 64;
    localparam int WIDTH = 16;
    localparam int IDXW  = $clog2(NREC);
    localparam int CNTW  = $clog2(NREC + 1);

    // {key, mask} stimulus vectors
    localparam logic [31:0] VEC [8] = '{
        {16'h0000, 16'hFFFF},
        {16'h00F0, 16'hFFFF},
        {16'h00F0, 16'h00F0},
        {16'h0001, 16'h0001},
        {16'h8000, 16'h8000},
        {16'h1234, 16'h0F0F},
        {16'hFFFF, 16'hFFFF},
        {16'h0000, 16'h0003}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDXW-1:0]  wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             start = 1'b0;
    logic [WIDTH-1:0] key = '0;
    logic [WIDTH-1:0] mask = '0;
    logic             busy, done, hit_valid;
    logic [NREC-1:0]  match_vec;
    logic [IDXW-1:0]  hit_index;
    logic [CNTW-1:0]  match_count;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [WIDTH-1:0] refmem [NREC];
    logic [NREC-1:0]  exp_vec;
    logic [IDXW-1:0]  exp_first;
    logic             exp_valid;
    logic [CNTW-1:0]  exp_cnt;

    always #4 clk = ~clk;

    bitplane_search #(.NREC(NREC), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .key(key), .mask(mask),
        .busy(busy), .done(done), .match_vec(match_vec),
        .hit_index(hit_index), .hit_valid(hit_valid),
        .match_count(match_count)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] rec_init(input int i);
        logic [WIDTH-1:0] v;
        v = WIDTH'(i * 40503) ^ WIDTH'(i << 5);
        if (i % 9 == 0) v = '0;
        if (i % 13 == 5) v = 16'h00F0;
        return v;
    endfunction

    // Linear-scan reference model
    task automatic ref_search(input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m);
        exp_vec = '0;
        exp_cnt = '0;
        exp_valid = 1'b0;
        exp_first = '0;
        for (int i = 0; i < NREC; i++) begin
            if (((refmem[i] ^ k) & m) == '0) begin
                exp_vec[i] = 1'b1;
                exp_cnt = exp_cnt + 1'b1;
                if (!exp_valid) begin
                    exp_first = IDXW'(i);
                    exp_valid = 1'b1;
                end
            end
        end
    endtask

    task automatic write_rec(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = IDXW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        refmem[a] = d;
    endtask

    // inject: 0 none, 1 write during busy, 2 start during busy
    task automatic search(input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m,
                          input int inject, input string tag);
        int blen;
        ref_search(k, m);
        @(negedge clk);
        start = 1'b1; key = k; mask = m;
        @(negedge clk);
        start = 1'b0;
        blen = 0;
        while (busy && blen < 100) begin
            blen++;
            if (blen == 5 && inject == 1) begin
                wr_en = 1'b1; wr_addr = IDXW'(exp_first); wr_data = ~k;
            end
            if (blen == 5 && inject == 2) begin
                start = 1'b1; key = ~k; mask = '1;
            end
            if (blen == 6) begin
                wr_en = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        chk(blen == WIDTH + 2, {"R4/R7 busy length ", tag}, 64'(blen), 64'(WIDTH + 2));
        chk(done == 1'b1, {"R4 done at busy fall ", tag}, 64'(done), 64'd1);
        chk(match_vec == exp_vec, {"R2 match vector ", tag}, 64'(match_vec), 64'(exp_vec));
        chk(hit_valid == exp_valid, {"R5 hit valid ", tag}, 64'(hit_valid), 64'(exp_valid));
        chk(hit_index == exp_first, {"R5 hit index ", tag}, 64'(hit_index), 64'(exp_first));
        chk(match_count == exp_cnt, {"R6 match count ", tag}, 64'(match_count), 64'(exp_cnt));
        @(negedge clk);
        chk(done == 1'b0, {"R4 done one cycle ", tag}, 64'(done), 64'd0);
        chk(match_vec == exp_vec && match_count == exp_cnt, {"R10 outputs hold ", tag},
            64'(match_count), 64'(exp_cnt));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !hit_valid, "R1 reset flags", {61'd0, busy, done, hit_valid}, 64'd0);
        chk(match_vec == '0 && hit_index == '0 && match_count == '0, "R1 reset results",
            64'(match_vec), 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NREC; i++) write_rec(i, rec_init(i));

        // Table walk
        foreach (VEC[v]) search(VEC[v][31:16], VEC[v][15:0], 0, $sformatf("vec%0d", v));

        // R3 empty mask matches all
        search(16'hABCD, 16'h0000, 0, "R3 all-care-off");
        chk(match_count == CNTW'(NREC), "R3 count is NREC", 64'(match_count), 64'(NREC));
        // R5 no match anywhere
        search(16'h7E7E, 16'hFFFF, 0, "R5 no match");
        chk(!hit_valid && hit_index == '0, "R5 empty result", 64'(hit_index), 64'd0);
        // R9 all-zero record detection
        search(16'h0000, 16'hFFFF, 0, "R9 zero pattern");
        chk(match_vec[0] && match_vec[9] && !match_vec[1], "R9 zero records flagged",
            64'(match_vec), 64'(exp_vec));
        // R5 only the top record matches
        write_rec(NREC - 1, 16'hBEEF);
        search(16'hBEEF, 16'hFFFF, 0, "R5 top only");
        chk(hit_index == IDXW'(NREC - 1), "R5 top index", 64'(hit_index), 64'(NREC - 1));
        // R8 rewrite replaces the record
        write_rec(NREC - 1, 16'h1111);
        search(16'hBEEF, 16'hFFFF, 0, "R8 after rewrite");
        search(16'h1111, 16'hFFFF, 0, "R8 new value");
        // R7 write while busy is ignored (checked by a later search)
        search(16'h00F0, 16'hFFFF, 1, "R7 write injected");
        search(16'h00F0, 16'hFFFF, 0, "R7 record untouched");
        // R7 start while busy is ignored
        search(16'h0000, 16'hFFFF, 2, "R7 start injected");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule